// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterized number of level-sensitive interrupt inputs and combines them onto a small set of output lines, one line for every 64 inputs. Each input can be enabled or blocked per bit, and software can also force any input pending through a set register. The combined state is visible as 32-bit status words. A master-status word shows which output groups have work pending.

A one-hot channel-control word decides whether this instance forwards anything. An output rises only when the block's own channel bit is set and the master disable bit is clear. All state is reached through a plain 32-bit register bus. A write takes effect on a single-cycle strobe, and read data appears one cycle after the read request.

Register words are stored in reverse order: the word holding the highest-numbered inputs sits at the lowest offset of each region. The mask, set and status regions each hold R = NUM_IN/32 words and follow one another.

Top module: `irq_steer_hub`

## Requirements
- R1: After reset the channel word, all mask and set words and the master-disable bit are zero, irq_out is all zero, and every register reads back zero except the status and master-status words, which follow the live inputs (all zero while the mask is zero).
- R2: Input i belongs to word R-1-i/32, bit i%32. Mask word n is at byte offset 4+4n and set word n is at 4R+4+4n. Both are read/write. A mask bit of 1 enables its input.
- R3: Status word n, at byte offset 8R+4+4n, reads (input OR set bit) AND mask bit for the inputs of word n.
- R4: Writes to status words and to the master-status word change no register.
- R5: irq_out[k] is the OR of the pending bits of inputs 64k..64k+63 (fewer inputs in a last, partial group). It is registered, so it shows the inputs and registers of the previous cycle.
- R6: The channel word at byte offset 0 holds NUM_CHAN bits. The outputs forward anything only while bit CHAN_ID is set. Otherwise irq_out is zero.
- R7: Bit 0 of the master-disable word at byte offset 12R+4 forces all outputs to zero while set, and reads back.
- R8: Bit k of the master-status word at byte offset 12R+8 is 1 when group k has any pending bit, whatever the channel and master-disable state.
- R9: An address whose low two bits are not zero, or an aligned address above 12R+8, reads zero and ignores writes.
- R10: bus_rdata shows the value addressed in the cycle of bus_re during the following cycle, and is zero after a cycle without bus_re. A read and a write to the same word in the same cycle return the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Level interrupt inputs |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| irq_out | output | (NUM_IN+63)/64 | Combined group outputs |

## Verification
A bus access and a change of the interrupt state can land in the same cycle. The most direct case is a read and a write aimed at the same mask word. The bench drives both strobes on one edge and expects the old contents back, then expects the new contents on a second read. It also changes the raw inputs on the same edge as a mask or set write. It then checks that the output reflects both only after the register has settled and one further output stage has passed.

// File: rtl/irq_steer_hub.sv
module irq_steer_hub #(
  parameter int NUM_IN   = 128,
  parameter int NUM_CHAN = 8,
  parameter int CHAN_ID  = 2,
  parameter int ADDR_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             irq_in,
  input  logic                          bus_we,
  input  logic                          bus_re,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [(NUM_IN+63)/64-1:0]     irq_out
);
  localparam int R    = NUM_IN / 32;
  localparam int NOUT = (NUM_IN + 63) / 64;
  localparam int MDIS = 3 * R + 1;
  localparam int MSTA = 3 * R + 2;

  logic [NUM_CHAN-1:0] ctrl_q;
  logic [NUM_IN-1:0]   mask_q, set_q, pend;
  logic                mdis_q;
  logic [NOUT-1:0]     grp;
  logic [31:0]         rd_val;
  logic                aligned;
  int                  widx;
  logic                hit_ctrl, hit_mask, hit_set, hit_mdis;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign widx     = int'(bus_addr[ADDR_W-1:2]);
  assign hit_ctrl = aligned && widx == 0;
  assign hit_mask = aligned && widx >= 1 && widx <= R;
  assign hit_set  = aligned && widx >= R + 1 && widx <= 2 * R;
  assign hit_mdis = aligned && widx == MDIS;

  assign pend = (irq_in | set_q) & mask_q;

  for (genvar k = 0; k < NOUT; k++) begin : g_grp
    localparam int LO = 64 * k;
    localparam int W  = (NUM_IN - LO >= 64) ? 64 : NUM_IN - LO;
    assign grp[k] = |pend[LO +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      set_q  <= '0;
      mdis_q <= 1'b0;
    end else if (bus_we) begin
      if (hit_ctrl) ctrl_q <= bus_wdata[NUM_CHAN-1:0];
      if (hit_mdis) mdis_q <= bus_wdata[0];
      for (int n = 0; n < R; n++) begin
        if (aligned && widx == 1 + n)     mask_q[(R-1-n)*32 +: 32] <= bus_wdata;
        if (aligned && widx == R + 1 + n) set_q[(R-1-n)*32 +: 32]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) rd_val = 32'(ctrl_q);
    if (hit_mdis) rd_val = {31'd0, mdis_q};
    if (aligned && widx == MSTA) rd_val = 32'(grp);
    for (int n = 0; n < R; n++) begin
      if (aligned && widx == 1 + n)         rd_val = mask_q[(R-1-n)*32 +: 32];
      if (aligned && widx == R + 1 + n)     rd_val = set_q[(R-1-n)*32 +: 32];
      if (aligned && widx == 2 * R + 1 + n) rd_val = pend[(R-1-n)*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_out   <= '0;
    end else begin
      bus_rdata <= bus_re ? rd_val : 32'd0;
      irq_out   <= (ctrl_q[CHAN_ID] && !mdis_q) ? grp : '0;
    end
  end

  // R6 R7
  gated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CHAN_ID] || mdis_q) |=> (irq_out == '0));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_out == '0));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == 32'd0));

  // R4 R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(hit_ctrl || hit_mask || hit_set || hit_mdis)) |=>
      ($stable(ctrl_q) && $stable(mask_q) && $stable(set_q) && $stable(mdis_q)));

  // R8
  mstat_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && aligned && widx == MSTA && pend == '0) |=> (bus_rdata == 32'd0));
endmodule

// File: tb/irq_steer_hub_bench.sv
module irq_steer_hub_bench;
  localparam int NUM_IN = 128, NUM_CHAN = 8, CHAN_ID = 2, ADDR_W = 10;
  localparam int R = NUM_IN / 32, NOUT = (NUM_IN + 63) / 64;

  logic clk = 0, rst_n = 0, bus_we = 0, bus_re = 0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NOUT-1:0] irq_out;

  irq_steer_hub #(.NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID), .ADDR_W(ADDR_W))
    u_irq_steer_hub (.clk, .rst_n, .irq_in, .bus_we, .bus_re, .bus_addr,
                     .bus_wdata, .bus_rdata, .irq_out);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NUM_IN-1:0] m_mask = '0, m_set = '0;
  logic [NUM_CHAN-1:0] m_ctrl = '0;
  logic m_mdis = 0;

  function automatic int a_mask(int n); return 4 + 4 * n; endfunction
  function automatic int a_set(int n);  return 4 * R + 4 + 4 * n; endfunction
  function automatic int a_stat(int n); return 8 * R + 4 + 4 * n; endfunction
  localparam int A_MDIS = 12 * R + 4, A_MSTA = 12 * R + 8;

  function automatic logic [NUM_IN-1:0] e_pend();
    return (irq_in | m_set) & m_mask;
  endfunction
  function automatic logic [31:0] e_word(logic [NUM_IN-1:0] v, int n);
    return v[(R-1-n)*32 +: 32];
  endfunction
  function automatic logic [NOUT-1:0] e_grp();
    logic [NOUT-1:0] g = '0;
    logic [NUM_IN-1:0] p = e_pend();
    for (int i = 0; i < NUM_IN; i++) if (p[i]) g[i/64] = 1'b1;
    return g;
  endfunction
  function automatic logic [NOUT-1:0] e_out();
    return (m_ctrl[CHAN_ID] && !m_mdis) ? e_grp() : '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    bus_we = 1; bus_addr = ADDR_W'(addr); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(int addr, logic [31:0] exp, string tag);
    bus_re = 1; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_re = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr_mask(int n, logic [31:0] d);
    wr(a_mask(n), d); m_mask[(R-1-n)*32 +: 32] = d;
  endtask
  task automatic wr_set(int n, logic [31:0] d);
    wr(a_set(n), d); m_set[(R-1-n)*32 +: 32] = d;
  endtask

  task automatic chk_out(string tag);
    @(negedge clk);
    check(tag, 32'(irq_out), 32'(e_out()));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", 32'(irq_out), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(0, 0, "R1 ctrl");
    for (int n = 0; n < R; n++) begin
      rd(a_mask(n), 0, "R1 mask");
      rd(a_set(n), 0, "R1 set");
    end
    rd(A_MDIS, 0, "R1 mdis");
    // R2 mapping: input 127 -> word 0 bit 31, input 0 -> word R-1 bit 0
    wr_mask(0, 32'h8000_0000);
    wr_mask(R-1, 32'h0000_0001);
    rd(a_mask(0), 32'h8000_0000, "R2 mask w0");
    rd(a_mask(R-1), 32'h1, "R2 mask wlast");
    wr(0, 32'(1 << CHAN_ID)); m_ctrl = NUM_CHAN'(1 << CHAN_ID);
    rd(0, 32'(1 << CHAN_ID), "R6 ctrl readback");
    irq_in = '0; irq_in[NUM_IN-1] = 1'b1;
    chk_out("R2 top input -> top group");
    check("R5 top group", 32'(irq_out), 32'(1 << (NOUT-1)));
    rd(a_stat(0), 32'h8000_0000, "R3 status w0");
    irq_in = '0; irq_in[0] = 1'b1;
    chk_out("R5 low input");
    check("R2 input0 -> out0", 32'(irq_out), 32'h1);
    // R2 set word forces pending
    irq_in = '0;
    wr_set(R-1, 32'h0000_0001);
    chk_out("R2 set forces");
    check("R2 set forces out0", 32'(irq_out), 32'h1);
    rd(a_set(R-1), 32'h1, "R2 set readback");
    // R4 status write ignored
    wr(a_stat(R-1), 32'h0);
    rd(a_stat(R-1), 32'h1, "R4 status write ignored");
    wr(A_MSTA, 32'hFFFF_FFFF);
    rd(A_MSTA, 32'h1, "R8 mstat / R4 write ignored");
    rd(a_mask(R-1), 32'h1, "R4 mask untouched");
    // R7 master disable
    wr(A_MDIS, 32'h1); m_mdis = 1;
    rd(A_MDIS, 32'h1, "R7 readback");
    chk_out("R7 disabled");
    check("R7 out zero", 32'(irq_out), 0);
    rd(A_MSTA, 32'h1, "R8 mstat while disabled");
    wr(A_MDIS, 32'h0); m_mdis = 0;
    // R6 other channel
    wr(0, 32'(1 << ((CHAN_ID + 1) % NUM_CHAN))); m_ctrl = NUM_CHAN'(1 << ((CHAN_ID + 1) % NUM_CHAN));
    chk_out("R6 other channel");
    check("R6 out zero", 32'(irq_out), 0);
    wr(0, 32'(1 << CHAN_ID)); m_ctrl = NUM_CHAN'(1 << CHAN_ID);
    // R9 unmapped and unaligned
    wr(a_mask(0) + 1, 32'hFFFF_FFFF);
    rd(a_mask(0), m_mask[(R-1)*32 +: 32], "R9 unaligned write ignored");
    rd(a_mask(0) + 2, 0, "R9 unaligned read zero");
    wr(A_MSTA + 4, 32'hFFFF_FFFF);
    rd(A_MSTA + 4, 0, "R9 unmapped read zero");
    rd(0, 32'(m_ctrl), "R9 ctrl untouched");
    // R10 same-cycle read and write
    bus_we = 1; bus_re = 1; bus_addr = ADDR_W'(a_mask(1)); bus_wdata = 32'hA5A5_0F0F;
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    check("R10 read-before-write", bus_rdata, e_word(m_mask, 1));
    m_mask[(R-2)*32 +: 32] = 32'hA5A5_0F0F;
    rd(a_mask(1), 32'hA5A5_0F0F, "R10 new value");
    @(negedge clk);
    check("R10 idle zero", bus_rdata, 0);
    // random mix: inputs change on the same edge as register writes
    for (int it = 0; it < 300; it++) begin
      int n = $urandom_range(R-1);
      irq_in = {$urandom, $urandom, $urandom, $urandom};
      case ($urandom_range(3))
        0: wr_mask(n, $urandom & $urandom);
        1: wr_set(n, ($urandom & $urandom & $urandom));
        2: begin m_mdis = ($urandom_range(7) == 0); wr(A_MDIS, 32'(m_mdis)); end
        default: @(negedge clk);
      endcase
      chk_out("R5 random out");
      rd(a_stat(n), e_word(e_pend(), n), "R3 random status");
      rd(A_MSTA, 32'(e_grp()), "R8 random mstat");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule